// File: doc/BRIEF.md
# PCM Codec Control and Loopback Router

This block is the digital control part of a single-channel 8-bit PCM codec. Software-free setup arrives as 8-bit control words on a serial line. A select input marks which of two control registers a word is meant for, and a strobe frames the word. The first register holds a two-bit function field that picks one of four modes: normal, analog loopback, digital loopback and powerdown. The second register holds a two-bit test field that is decoded onto three test-mode flags.

The block also steers PCM traffic. Each frame begins with a one-cycle sync and is followed by an 8-cycle slot. During the slot a byte is shifted in from the PCM serial input and a byte is shifted out on a serial output that has its own drive enable. Parallel ports lead to the encoder, which supplies the byte to send, and to the decoder, which receives the byte that came in. The routing between these ports depends on the mode in force for the current frame. Analog loopback only raises flags that a neighbouring analog section acts on.

Top module: `pcm_ctl_loop`

## Requirements
- R1: A control word is taken MSB first, one bit on each clock in which `cfg_stb` is high. The target register changes only in the cycle after `cfg_stb` falls, and only if exactly 8 bits were shifted during that strobe. A shorter or longer word leaves both registers unchanged.
- R2: `cfg_sel` as sampled on the last strobed bit picks the target: 0 selects the mode register (A) and 1 selects the test register (B). Only bits 7 and 6 (the first two bits received) of each word are kept.
- R3: After reset, register A holds the powerdown code and register B holds 00. A write whose strobe ends on any of the first 25 clock edges after reset release is ignored.
- R4: The code in A[7:6] selects the mode: 00 normal, 01 analog loopback, 10 digital loopback, 11 powerdown. `pwr_dn` is high in powerdown. `fb_en` and `obuf_gnd` are both high in analog loopback and low in every other mode.
- R5: A new mode code takes effect only on the edge that accepts a frame sync. Mode outputs and routing stay unchanged between frame starts.
- R6: A frame sync is accepted when no slot is running, or during the last bit of a running slot. The 8 following cycles form the slot. `pcm_sdi` is sampled MSB first on each slot edge, and `pcm_sdo` presents its byte MSB first with `pcm_oe` high for exactly those 8 cycles.
- R7: In normal mode, `enc_data` as sampled on the frame-start edge is sent in that slot. The byte received is placed on `dec_data`, and `dec_stb` pulses for one cycle just after the last slot bit.
- R8: In digital loopback, the slot sends the byte most recently completed on `pcm_sdi` (the previous frame's byte) and ignores `enc_data`. `dec_data` is forced to zero and `dec_stb` still pulses.
- R9: In analog loopback, the data paths behave as in normal mode while the two loopback flags are raised.
- R10: In powerdown, `pcm_oe` stays low for the whole frame, `dec_data` is zero and `dec_stb` does not pulse.
- R11: B[7:6] drives the test flags: 00 none, 01 `tst_tx`, 10 `tst_rx`, 11 `tst_codec`. At most one flag is high, and each follows register B directly without waiting for a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sdi | input | 1 | Serial control data, MSB first |
| cfg_sel | input | 1 | Register select: 0 mode register, 1 test register |
| cfg_stb | input | 1 | High while control bits are shifted |
| frm_sync | input | 1 | One-cycle frame sync, precedes the slot |
| pcm_sdi | input | 1 | Serial PCM input |
| pcm_sdo | output | 1 | Serial PCM output data |
| pcm_oe | output | 1 | Drive enable for the 3-state PCM output |
| enc_data | input | 8 | Encoder result byte |
| dec_data | output | 8 | Byte presented to the decoder |
| dec_stb | output | 1 | One-cycle pulse marking a new decoder byte |
| pwr_dn | output | 1 | Powerdown mode active |
| fb_en | output | 1 | Request receive-to-transmit analog feedback |
| obuf_gnd | output | 1 | Request grounding of the analog output buffer |
| tst_tx | output | 1 | Transmit filter test mode |
| tst_rx | output | 1 | Receive filter test mode |
| tst_codec | output | 1 | Codec test mode |

## Verification
On every cycle the assertions check the following: the registers stay frozen through the post-reset lock window and after a strobe with the wrong bit count, the mode changes only on an accepted frame sync, the output enable stays off whenever powerdown is flagged, and the decoder strobes only zero while digital loopback is in force. Other behaviour needs the bench's scenarios and its behavioural reference model. These are the one-frame delay of looped-back data, the MSB-first bit order on both serial lines, the choice of source byte at each frame start, back-to-back frames chained on the last bit, and the exact cycle in which a late write is first accepted.

// File: rtl/pcm_ctl_pkg.sv
package pcm_ctl_pkg;
  typedef enum logic [1:0] {
    MD_NORM = 2'b00,
    MD_ALB  = 2'b01,
    MD_DLB  = 2'b10,
    MD_PDN  = 2'b11
  } pcm_mode_e;

  // decoder byte for a mode: data passes only in normal and analog loopback
  function automatic logic [7:0] dec_route(input pcm_mode_e m, input logic [7:0] b);
    return (m == MD_NORM || m == MD_ALB) ? b : 8'h00;
  endfunction

  // source byte for the transmit slot
  function automatic logic [7:0] tx_route(input pcm_mode_e m, input logic [7:0] looped,
                                          input logic [7:0] enc);
    return (m == MD_DLB) ? looped : enc;
  endfunction
endpackage

// File: rtl/pcm_cfg_port.sv
module pcm_cfg_port
  import pcm_ctl_pkg::*;
#(
  parameter int W        = 8,
  parameter int LOCK_CYC = 25
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_sdi,
  input  logic      cfg_sel,
  input  logic      cfg_stb,
  output pcm_mode_e mode_req,
  output logic [1:0] test_sel,
  output logic      locked
);
  localparam int CW = $clog2(W + 2);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] SAT  = CW'(W + 1);
  localparam logic [LW-1:0] LOCK_L = LW'(LOCK_CYC);

  logic [W-1:0]  shreg;
  logic [CW-1:0] bit_cnt;
  logic          sel_q, stb_q;
  logic [LW-1:0] lock_cnt;

  // named events for the assertions
  wire stb_end   = stb_q & ~cfg_stb;
  wire word_full = (bit_cnt == FULL);
  wire wr_fire   = stb_end & word_full & ~locked;

  assign locked = (lock_cnt < LOCK_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_cnt <= '0;
    end else if (locked) begin
      lock_cnt <= lock_cnt + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      sel_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= cfg_stb;
      if (cfg_stb) begin
        shreg   <= {shreg[W-2:0], cfg_sdi};
        bit_cnt <= (bit_cnt == SAT) ? bit_cnt : bit_cnt + CW'(1);
        sel_q   <= cfg_sel;
      end else begin
        bit_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_req <= MD_PDN;
      test_sel <= 2'b00;
    end else if (wr_fire) begin
      if (sel_q) test_sel <= shreg[W-1 -: 2];
      else       mode_req <= pcm_mode_e'(shreg[W-1 -: 2]);
    end
  end

  // R3: registers frozen while the post-reset lock is in force
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(mode_req) && $stable(test_sel)));

  // R1: a strobe ending with the wrong bit count changes nothing
  p_partial_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_end && !word_full) |=> ($stable(mode_req) && $stable(test_sel)));
endmodule

// File: rtl/pcm_slot_engine.sv
module pcm_slot_engine
  import pcm_ctl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frm_sync,
  input  logic         pcm_sdi,
  input  logic [W-1:0] enc_data,
  input  pcm_mode_e    mode_req,
  output pcm_mode_e    mode_act,
  output logic         pcm_sdo,
  output logic         pcm_oe,
  output logic [W-1:0] dec_data,
  output logic         dec_stb
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST = BW'(W - 1);

  logic         slot;
  logic [BW-1:0] bit_cnt;
  logic [W-1:0] rx_sr, pcm_in, tx_sr;

  wire         last_bit    = slot && (bit_cnt == LAST);
  wire         frame_start = frm_sync && (!slot || last_bit);
  wire [W-1:0] rx_word     = {rx_sr[W-2:0], pcm_sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot     <= 1'b0;
      bit_cnt  <= '0;
      mode_act <= MD_PDN;
      tx_sr    <= '0;
      rx_sr    <= '0;
      pcm_in   <= '0;
    end else begin
      if (frame_start) begin
        slot     <= 1'b1;
        bit_cnt  <= '0;
        mode_act <= mode_req;
        tx_sr    <= tx_route(mode_req, pcm_in, enc_data);
      end else if (slot) begin
        bit_cnt <= bit_cnt + BW'(1);
        tx_sr   <= tx_sr << 1;
        if (last_bit) slot <= 1'b0;
      end
      if (slot)     rx_sr  <= rx_word;
      if (last_bit) pcm_in <= rx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_data <= '0;
      dec_stb  <= 1'b0;
    end else begin
      dec_stb <= 1'b0;
      if (last_bit) begin
        dec_data <= dec_route(mode_act, rx_word);
        dec_stb  <= (mode_act != MD_PDN);
      end else if (frame_start && (mode_req == MD_DLB || mode_req == MD_PDN)) begin
        dec_data <= '0;
      end
    end
  end

  assign pcm_oe  = slot && (mode_act != MD_PDN);
  assign pcm_sdo = tx_sr[W-1];

  // R5: the active mode moves only on an accepted frame sync
  p_mode_at_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_act));
endmodule

// File: rtl/pcm_mode_dec.sv
module pcm_mode_dec
  import pcm_ctl_pkg::*;
(
  input  pcm_mode_e  mode_act,
  input  logic [1:0] test_sel,
  output logic       pwr_dn,
  output logic       fb_en,
  output logic       obuf_gnd,
  output logic       dl_active,
  output logic       tst_tx,
  output logic       tst_rx,
  output logic       tst_codec
);
  always_comb begin
    pwr_dn    = (mode_act == MD_PDN);
    fb_en     = (mode_act == MD_ALB);
    obuf_gnd  = (mode_act == MD_ALB);
    dl_active = (mode_act == MD_DLB);
    tst_tx    = (test_sel == 2'b01);
    tst_rx    = (test_sel == 2'b10);
    tst_codec = (test_sel == 2'b11);
  end
endmodule

// File: rtl/pcm_ctl_loop.sv
module pcm_ctl_loop
  import pcm_ctl_pkg::*;
#(
  parameter int W        = 8,
  parameter int LOCK_CYC = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_sdi,
  input  logic         cfg_sel,
  input  logic         cfg_stb,
  input  logic         frm_sync,
  input  logic         pcm_sdi,
  output logic         pcm_sdo,
  output logic         pcm_oe,
  input  logic [W-1:0] enc_data,
  output logic [W-1:0] dec_data,
  output logic         dec_stb,
  output logic         pwr_dn,
  output logic         fb_en,
  output logic         obuf_gnd,
  output logic         tst_tx,
  output logic         tst_rx,
  output logic         tst_codec
);
  pcm_mode_e  mode_req, mode_act;
  logic [1:0] test_sel;
  logic       locked, dl_active;

  pcm_cfg_port #(.W(W), .LOCK_CYC(LOCK_CYC)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_sdi(cfg_sdi), .cfg_sel(cfg_sel), .cfg_stb(cfg_stb),
    .mode_req(mode_req), .test_sel(test_sel), .locked(locked)
  );

  pcm_slot_engine #(.W(W)) i_slot (
    .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync), .pcm_sdi(pcm_sdi),
    .enc_data(enc_data), .mode_req(mode_req), .mode_act(mode_act),
    .pcm_sdo(pcm_sdo), .pcm_oe(pcm_oe), .dec_data(dec_data), .dec_stb(dec_stb)
  );

  pcm_mode_dec i_dec (
    .mode_act(mode_act), .test_sel(test_sel), .pwr_dn(pwr_dn), .fb_en(fb_en),
    .obuf_gnd(obuf_gnd), .dl_active(dl_active), .tst_tx(tst_tx), .tst_rx(tst_rx),
    .tst_codec(tst_codec)
  );

  // R10: output never driven while powerdown is flagged
  p_pdn_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !pcm_oe);

  // R8: decoder sees only zero when a byte completes in digital loopback
  p_dlb_dec_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && $past(dl_active)) |-> (dec_data == '0));

  // R11: test flags never overlap
  p_test_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tst_tx, tst_rx, tst_codec}));
endmodule

// File: tb/test_pcm_ctl_loop.sv
`timescale 1ns/1ps
module test_pcm_ctl_loop;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sdi = 1'b0, cfg_sel = 1'b0, cfg_stb = 1'b0;
  logic frm_sync = 1'b0, pcm_sdi = 1'b0;
  logic [7:0] enc_data = 8'h00;
  logic pcm_sdo, pcm_oe, dec_stb, pwr_dn, fb_en, obuf_gnd, tst_tx, tst_rx, tst_codec;
  logic [7:0] dec_data;

  always #10 clk = ~clk;  // 50 MHz

  pcm_ctl_loop i_pcm_ctl_loop (
    .clk(clk), .rst_n(rst_n), .cfg_sdi(cfg_sdi), .cfg_sel(cfg_sel), .cfg_stb(cfg_stb),
    .frm_sync(frm_sync), .pcm_sdi(pcm_sdi), .pcm_sdo(pcm_sdo), .pcm_oe(pcm_oe),
    .enc_data(enc_data), .dec_data(dec_data), .dec_stb(dec_stb), .pwr_dn(pwr_dn),
    .fb_en(fb_en), .obuf_gnd(obuf_gnd), .tst_tx(tst_tx), .tst_rx(tst_rx),
    .tst_codec(tst_codec)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  string cur_req = "R3";

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_edges, m_cnt, m_bit, m_mode, m_a, m_b;
  bit   m_sel, m_stbq, m_slot, m_stb;
  bit [7:0] m_sh, m_rx, m_in, m_dec;
  bit   txq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edges = 0; m_cnt = 0; m_bit = 0; m_mode = 3; m_a = 3; m_b = 0;
      m_sel = 0; m_stbq = 0; m_slot = 0; m_stb = 0;
      m_sh = 0; m_rx = 0; m_in = 0; m_dec = 0; txq.delete();
    end else begin
      bit start, last;
      bit [7:0] word, old_in, src;
      int old_mode, old_a;
      start = frm_sync && (!m_slot || m_bit == 7);
      last  = m_slot && m_bit == 7;
      word  = {m_rx[6:0], pcm_sdi};
      old_mode = m_mode; old_in = m_in; old_a = m_a;
      m_stb = 0;
      if (last) begin
        m_in = word;
        if (old_mode <= 1) begin m_dec = word; m_stb = 1; end
        else if (old_mode == 2) begin m_dec = 0; m_stb = 1; end
        else m_dec = 0;
      end else if (start && old_a >= 2) m_dec = 0;
      if (m_slot) begin
        m_rx = word;
        if (txq.size() > 0) void'(txq.pop_front());
      end
      if (start) begin
        m_mode = old_a;
        src = (old_a == 2) ? old_in : enc_data;
        txq.delete();
        for (int i = 7; i >= 0; i--) txq.push_back(src[i]);
        m_slot = 1; m_bit = 0;
      end else if (m_slot) begin
        if (m_bit == 7) m_slot = 0;
        m_bit = (m_bit + 1) % 8;
      end
      if (cfg_stb) begin
        m_sh = {m_sh[6:0], cfg_sdi};
        if (m_cnt < 9) m_cnt++;
        m_sel = cfg_sel;
      end else begin
        if (m_stbq && m_cnt == 8 && m_edges >= 25) begin
          if (m_sel) m_b = m_sh[7:6]; else m_a = m_sh[7:6];
        end
        m_cnt = 0;
      end
      m_stbq = cfg_stb;
      if (m_edges < 25) m_edges++;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit eoe;
      eoe = m_slot && (m_mode != 3);
      check(cur_req, "pcm_oe", pcm_oe, eoe);
      if (eoe && txq.size() > 0) check(cur_req, "pcm_sdo", pcm_sdo, txq[0]);
      check(cur_req, "dec_data", dec_data, m_dec);
      check(cur_req, "dec_stb", dec_stb, m_stb);
      check(cur_req, "pwr_dn", pwr_dn, m_mode == 3);
      check(cur_req, "fb_en", fb_en, m_mode == 1);
      check(cur_req, "obuf_gnd", obuf_gnd, m_mode == 1);
      check(cur_req, "tst_tx", tst_tx, m_b == 1);
      check(cur_req, "tst_rx", tst_rx, m_b == 2);
      check(cur_req, "tst_codec", tst_codec, m_b == 3);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input bit sel, input bit [7:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      cfg_stb = 1'b1; cfg_sel = sel; cfg_sdi = w[7 - (i % 8)];
    end
    @(negedge clk);
    cfg_stb = 1'b0; cfg_sdi = 1'b0;
    idle(2);
  endtask

  // lead: drive a sync cycle first; chain: sync on the last bit for the next frame
  task automatic send_frame(input bit [7:0] rx, input bit [7:0] enc, input bit lead,
                            input bit chain);
    if (lead) begin
      @(negedge clk);
      enc_data = enc; frm_sync = 1'b1; pcm_sdi = 1'b0;
    end
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      pcm_sdi = rx[i];
      frm_sync = (i == 0) && chain;
      if (i == 0 && chain) enc_data = enc;
    end
    @(negedge clk);
    frm_sync = 1'b0; pcm_sdi = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    cur_req = "R3";
    // write attempt inside the lock window
    cfg_write(1'b0, 8'h00, 8);
    check("R3", "pwr_dn after locked write", pwr_dn, 1);
    idle(20);
    send_frame(8'h11, 8'hA5, 1'b1, 1'b0);
    cur_req = "R10";
    send_frame(8'h22, 8'hA5, 1'b1, 1'b0);
    check("R10", "pcm_oe in powerdown", pcm_oe, 0);

    cur_req = "R1";
    cfg_write(1'b0, 8'h00, 5);     // short word
    cfg_write(1'b0, 8'h00, 9);     // long word
    send_frame(8'h33, 8'h12, 1'b1, 1'b0);
    check("R1", "mode kept after bad lengths", pwr_dn, 1);

    cur_req = "R2";
    cfg_write(1'b0, 8'h00, 8);     // A = normal
    cur_req = "R5";
    check("R5", "mode waits for frame", pwr_dn, 1);
    cur_req = "R6";
    send_frame(8'h96, 8'h3C, 1'b1, 1'b0);
    check("R5", "mode applied at frame", pwr_dn, 0);
    cur_req = "R7";
    send_frame(8'h01, 8'hC3, 1'b1, 1'b0);
    send_frame(8'h80, 8'h7E, 1'b1, 1'b1);
    send_frame(8'hF0, 8'h0F, 1'b0, 1'b0);

    cur_req = "R9";
    cfg_write(1'b0, 8'h40, 8);
    send_frame(8'h5A, 8'h99, 1'b1, 1'b0);
    check("R9", "fb_en in analog loopback", fb_en, 1);
    check("R4", "obuf_gnd in analog loopback", obuf_gnd, 1);
    send_frame(8'hA7, 8'h66, 1'b1, 1'b0);

    cur_req = "R8";
    cfg_write(1'b0, 8'h80, 8);
    send_frame(8'h5A, 8'hFF, 1'b1, 1'b0);
    send_frame(8'hC3, 8'hFF, 1'b1, 1'b1);
    send_frame(8'h3E, 8'h00, 1'b0, 1'b0);
    send_frame(8'h00, 8'hFF, 1'b1, 1'b0);
    check("R8", "fb_en in digital loopback", fb_en, 0);

    cur_req = "R11";
    cfg_write(1'b1, 8'h40, 8);
    check("R11", "tst_tx", tst_tx, 1);
    cfg_write(1'b1, 8'h80, 8);
    check("R11", "tst_rx", tst_rx, 1);
    cfg_write(1'b1, 8'hFF, 8);
    check("R11", "tst_codec", tst_codec, 1);
    cfg_write(1'b1, 8'h3F, 8);
    check("R11", "tests cleared", tst_tx | tst_rx | tst_codec, 0);

    cur_req = "R4";
    cfg_write(1'b0, 8'h00, 8);
    send_frame(8'h44, 8'h81, 1'b1, 1'b0);
    cur_req = "R10";
    cfg_write(1'b0, 8'hC0, 8);
    send_frame(8'h55, 8'h81, 1'b1, 1'b1);
    send_frame(8'h66, 8'h18, 1'b0, 1'b0);
    check("R10", "powerdown re-entered", pwr_dn, 1);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule